// File: doc/BRIEF.md
# Timer Cell Input Routing Crossbar

The crossbar delivers one signal to each of 32 timer cell inputs, which are arranged as four cell groups of eight. Every cell input takes its signal from one of three source classes. The first class is any line of four general I/O groups of eight lines each. The second is a line of an eight-line clock bus. The third is a line of a mixed group of eight, made of four phase-discriminator lines and four interrupt lines. Taken together, the routing behaves as a set of 8x8 switch matrices, one for each pairing of a source group with a cell group. One source line may feed any number of cell inputs, but a cell input never has more than one driver.

Each cell input has one 8-bit selection word, written through a small register port. The word holds an enable bit, a source class, an I/O group index and a line index. The word chooses a single source, so a conflicting selection cannot be written at all. Configuration is clocked and resets to disabled. The path from a source line to a cell input is purely combinational.

Top module: `tcx_input_xbar`

## Requirements
- R1: While `rst` is high at a rising clock edge, every selection word is cleared to 0x00. After reset, every cell input is 0 and every readback returns 0x00, whatever the source lines carry.
- R2: A rising edge with `cfg_we` high stores `cfg_wdata` into the selection word at `cfg_addr`. Every other word keeps its value. `cfg_rdata` shows the word at `cfg_addr` combinationally.
- R3: Selection word layout: bit 7 = enable; bits 6:5 = class (0 = I/O group, 1 = clock bus, 2 = discriminator/interrupt group, 3 = reserved); bits 4:3 = I/O group index; bits 2:0 = line index.
- R4: An enabled word with class 0 drives its cell input from `io_in[8*group + line]`.
- R5: An enabled word with class 1 drives its cell input from `clk_bus[line]`.
- R6: An enabled word with class 2 drives its cell input from `disc_in[line]` for lines 0..3 and from `irq_in[line-4]` for lines 4..7.
- R7: A cell input whose word has the enable bit clear, or has class 3, is driven to 0.
- R8: Any number of cell inputs may select the same source line, and each of them follows that line.
- R9: The word at address k controls `cell_in[k]`. Cell k is position k%8 of cell group k/8.
- R10: A source change reaches the selected cell inputs in the same cycle, with no clock edge. A new selection takes effect right after the edge that writes it, and not before.
- R11: The I/O group index has no effect for classes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a selection word |
| cfg_addr | input | 5 | Selection word address (cell index) |
| cfg_wdata | input | 8 | Selection word to write |
| cfg_rdata | output | 8 | Selection word at `cfg_addr` |
| io_in | input | 32 | Four I/O groups; group g uses bits 8g+7..8g |
| clk_bus | input | 8 | Clock bus lines |
| disc_in | input | 4 | Phase-discriminator lines |
| irq_in | input | 4 | Interrupt lines |
| cell_in | output | 32 | Timer cell inputs; bit k goes to cell k |

## Verification
A corrupted selection word shows at the ports in two ways. The affected cell input follows the wrong line, or stays at 0, as soon as the sources differ. The readback of that word also differs right after the edge that should have set it. Because the data path has no registers, a wrong class decode or a wrong line index shows within the same cycle in which the bench toggles the source. The bench drives distinct patterns on every source, so a mis-wired group or a swapped half of the discriminator/interrupt group changes at least one of the 32 outputs.

// File: rtl/tcx_pkg.sv
package tcx_pkg;

    localparam int unsigned LINES       = 8;
    localparam int unsigned LINE_IDX_W  = $clog2(LINES);
    localparam int unsigned IO_GROUPS   = 4;
    localparam int unsigned IOG_IDX_W   = $clog2(IO_GROUPS);
    localparam int unsigned CELL_GROUPS = 4;
    localparam int unsigned CELLS       = CELL_GROUPS * LINES;
    localparam int unsigned CELL_IDX_W  = $clog2(CELLS);
    localparam int unsigned DISC_N      = LINES / 2;

    typedef enum logic [1:0] {
        SRC_IO   = 2'd0,
        SRC_CLK  = 2'd1,
        SRC_PDI  = 2'd2,
        SRC_RSVD = 2'd3
    } src_class_e;

    typedef struct packed {
        logic                  en;
        src_class_e            cls;
        logic [IOG_IDX_W-1:0]  grp;
        logic [LINE_IDX_W-1:0] line;
    } cell_sel_t;

    localparam int unsigned SEL_W = $bits(cell_sel_t);

    // A word routes something only when enabled and of a real class
    function automatic logic sel_active(input cell_sel_t s);
        return s.en && (s.cls != SRC_RSVD);
    endfunction

endpackage

// File: rtl/tcx_cfg_bank.sv
module tcx_cfg_bank
    import tcx_pkg::*;
#(
    parameter int unsigned N_WORDS = CELLS,
    localparam int unsigned ADDR_W = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  wdata,
    output logic [SEL_W-1:0]  rdata,
    output cell_sel_t         sel_o [N_WORDS]
);

    cell_sel_t cfg_q [N_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < int'(N_WORDS); k++) begin
                cfg_q[k] <= '0;
            end
        end else if (we) begin
            cfg_q[addr] <= cell_sel_t'(wdata);
        end
    end

    assign rdata = cfg_q[addr];

    for (genvar k = 0; k < int'(N_WORDS); k++) begin : g_word
        assign sel_o[k] = cfg_q[k];

        // R1: reset leaves every word cleared
        a_r1_reset_clears: assert property (@(posedge clk)
            rst |=> (cfg_q[k] == '0));

        // R2: a word not addressed by a write keeps its value
        a_r2_others_hold: assert property (@(posedge clk) disable iff (rst)
            !(we && (addr == ADDR_W'(k))) |=> $stable(cfg_q[k]));
    end

    // R2: written data lands in the addressed word
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg_q[$past(addr)] == cell_sel_t'($past(wdata))));

endmodule

// File: rtl/tcx_cell_mux.sv
module tcx_cell_mux
    import tcx_pkg::*;
#(
    parameter int unsigned N_IO = IO_GROUPS * LINES
) (
    input  cell_sel_t          sel,
    input  logic [N_IO-1:0]    io_in,
    input  logic [LINES-1:0]   clk_bus,
    input  logic [LINES-1:0]   pdi_bus,
    output logic               y
);

    logic io_bit;

    assign io_bit = io_in[{sel.grp, sel.line}];

    always_comb begin
        y = 1'b0;
        if (sel.en) begin
            unique case (sel.cls)
                SRC_IO:   y = io_bit;
                SRC_CLK:  y = clk_bus[sel.line];
                SRC_PDI:  y = pdi_bus[sel.line];
                default:  y = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tcx_input_xbar.sv
module tcx_input_xbar
    import tcx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CELL_IDX_W-1:0] cfg_addr,
    input  logic [SEL_W-1:0]      cfg_wdata,
    output logic [SEL_W-1:0]      cfg_rdata,
    input  logic [IO_GROUPS*LINES-1:0] io_in,
    input  logic [LINES-1:0]      clk_bus,
    input  logic [DISC_N-1:0]     disc_in,
    input  logic [DISC_N-1:0]     irq_in,
    output logic [CELLS-1:0]      cell_in
);

    cell_sel_t        sel [CELLS];
    logic [LINES-1:0] pdi_bus;

    // Discriminator lines take the low half, interrupt lines the high half
    assign pdi_bus = {irq_in, disc_in};

    tcx_cfg_bank #(.N_WORDS(CELLS)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .sel_o (sel)
    );

    for (genvar cg = 0; cg < int'(CELL_GROUPS); cg++) begin : g_cgrp
        for (genvar p = 0; p < int'(LINES); p++) begin : g_pos
            localparam int unsigned K = cg * LINES + p;

            tcx_cell_mux u_mux (
                .sel     (sel[K]),
                .io_in   (io_in),
                .clk_bus (clk_bus),
                .pdi_bus (pdi_bus),
                .y       (cell_in[K])
            );

            // R7: disabled or reserved selection gives a low input
            a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
                !sel_active(sel[K]) |-> !cell_in[K]);

            // R5: clock class follows the chosen clock line
            a_r5_clock_follow: assert property (@(posedge clk) disable iff (rst)
                (sel[K].en && sel[K].cls == SRC_CLK)
                    |-> (cell_in[K] == clk_bus[sel[K].line]));

            // R6: upper half of the mixed group comes from the interrupt lines
            a_r6_irq_half: assert property (@(posedge clk) disable iff (rst)
                (sel[K].en && sel[K].cls == SRC_PDI && sel[K].line[LINE_IDX_W-1])
                    |-> (cell_in[K] == irq_in[sel[K].line[LINE_IDX_W-2:0]]));
        end
    end

endmodule

// File: tb/test_tcx_input_xbar.sv
module test_tcx_input_xbar;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic [31:0] io_in;
    logic [7:0]  clk_bus;
    logic [3:0]  disc_in;
    logic [3:0]  irq_in;
    logic [31:0] cell_in;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] model [32];

    always #2 clk = ~clk;

    tcx_input_xbar i_tcx_input_xbar (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_in(io_in),
        .clk_bus(clk_bus), .disc_in(disc_in), .irq_in(irq_in), .cell_in(cell_in)
    );

    function automatic logic ref_bit(input logic [7:0] w);
        logic [2:0] ln;
        ln = w[2:0];
        if (!w[7]) return 1'b0;
        case (w[6:5])
            2'd0: return io_in[{w[4:3], ln}];
            2'd1: return clk_bus[ln];
            2'd2: return ln[2] ? irq_in[ln[1:0]] : disc_in[ln[1:0]];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] ref_vec();
        logic [31:0] v;
        for (int k = 0; k < 32; k++) v[k] = ref_bit(model[k]);
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 32; k++) model[k] = 8'h00;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model[a] = d;
    endtask

    task automatic set_src(input logic [31:0] io, input logic [7:0] cb,
                           input logic [3:0] d, input logic [3:0] q);
        io_in = io; clk_bus = cb; disc_in = d; irq_in = q;
        #1;
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        set_src('1, '1, '1, '1);
        check("R1 outputs after reset", cell_in, 32'h0);
        for (int k = 0; k < 32; k += 7) begin
            cfg_addr = 5'(k); #0.5;
            check("R1 readback after reset", {24'h0, cfg_rdata}, 32'h0);
        end
    endtask

    // R2, R3: write and readback of every word
    task automatic t_readback();
        do_reset();
        for (int k = 0; k < 32; k++) wr(k, 8'((k * 37 + 5) & 8'hff));
        for (int k = 0; k < 32; k++) begin
            cfg_addr = 5'(k); #0.5;
            check("R2 readback", {24'h0, cfg_rdata}, {24'h0, model[k]});
        end
    endtask

    // R4, R9: I/O class with group and line spread over cells
    task automatic t_io();
        do_reset();
        for (int k = 0; k < 32; k++)
            wr(k, {1'b1, 2'd0, 2'(k % 4), 3'((k * 3) % 8)});
        set_src(32'hA5C3_0F96, 8'h00, 4'h0, 4'h0);
        check("R4 io pattern A", cell_in, ref_vec());
        set_src(32'h1234_89EF, 8'hFF, 4'hF, 4'hF);
        check("R4 io pattern B", cell_in, ref_vec());
        set_src(32'h0000_0001 << 13, 8'h00, 4'h0, 4'h0);
        check("R9 single io line", cell_in, ref_vec());
    endtask

    // R5, R10: clock class, source change seen without a clock edge
    task automatic t_clock();
        do_reset();
        for (int k = 0; k < 32; k++) wr(k, {1'b1, 2'd1, 2'd0, 3'(k % 8)});
        @(negedge clk);
        set_src('0, 8'b1011_0010, 4'h0, 4'h0);
        check("R5 clock pattern", cell_in, ref_vec());
        clk_bus = 8'b0100_1101; #0.5;
        check("R10 same-cycle source change", cell_in, ref_vec());
        check("R5 clock pattern complement", cell_in, {4{8'b0100_1101}});
    endtask

    // R6: discriminator low half, interrupt high half
    task automatic t_pdi();
        do_reset();
        for (int k = 0; k < 32; k++) wr(k, {1'b1, 2'd2, 2'd1, 3'(k % 8)});
        set_src('1, '1, 4'b0110, 4'b1001);
        check("R6 mixed group", cell_in, {4{8'b1001_0110}});
        set_src('0, '0, 4'b0000, 4'b1111);
        check("R6 interrupt half only", cell_in, {4{8'hF0}});
    endtask

    // R7: disabled and reserved selections
    task automatic t_idle();
        do_reset();
        for (int k = 0; k < 32; k++)
            wr(k, (k % 2 == 0) ? {1'b0, 2'd0, 2'(k % 4), 3'(k % 8)}
                               : {1'b1, 2'd3, 2'(k % 4), 3'(k % 8)});
        set_src('1, '1, '1, '1);
        check("R7 disabled or reserved low", cell_in, 32'h0);
    endtask

    // R8: one line fans out to every cell
    task automatic t_fanout();
        do_reset();
        for (int k = 0; k < 32; k++) wr(k, {1'b1, 2'd0, 2'd2, 3'd5});
        set_src(32'h1 << 21, '0, '0, '0);
        check("R8 fan-out high", cell_in, 32'hFFFF_FFFF);
        set_src(~(32'h1 << 21), '1, '1, '1);
        check("R8 fan-out low", cell_in, 32'h0);
    endtask

    // R11: group field ignored for clock and mixed classes
    task automatic t_grp_ignored();
        do_reset();
        for (int k = 0; k < 32; k++)
            wr(k, {1'b1, (k < 16) ? 2'd1 : 2'd2, 2'(k % 4), 3'(k % 8)});
        set_src(32'h0F0F_0F0F, 8'b1100_1010, 4'b0011, 4'b0101);
        check("R11 group field ignored", cell_in,
              {{2{8'b0101_0011}}, {2{8'b1100_1010}}});
    endtask

    // R10: new selection applies only after its write edge
    task automatic t_write_timing();
        do_reset();
        set_src(32'h0, 8'h04, 4'h0, 4'h0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'd9; cfg_wdata = {1'b1, 2'd1, 2'd0, 3'd2};
        #1;
        check("R10 before write edge", cell_in, 32'h0);
        @(negedge clk);
        cfg_we = 1'b0;
        model[9] = {1'b1, 2'd1, 2'd0, 3'd2};
        #0.5;
        check("R10 after write edge", cell_in, 32'h0000_0200);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        io_in = '0; clk_bus = '0; disc_in = '0; irq_in = '0;
        t_reset();
        t_readback();
        t_io();
        t_clock();
        t_pdi();
        t_idle();
        t_fanout();
        t_grp_ignored();
        t_write_timing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule